// File: doc/BRIEF.md
# Segmented Analog FIFO Controller

This controller runs a sampling memory that is split into many short segments and treats it as a queue of captured windows. A hit on the trigger input takes the next free segment and drives its write control for one full window. When the window is complete, the segment index joins a pending queue together with a timestamp taken at the moment of the hit. No external start command is needed, and the sampler is ready for a new hit as soon as the current window ends.

Pending segments are handed to a slower digitizer through a request and acknowledge handshake. This runs independently of writing, so bursts of hits are absorbed as long as the average rate stays within what the converter can drain. A second-level decision acts on the oldest pending segment. An accept releases it to the digitizer. A reject returns its index to the free pool at once, without any readout. A hit that finds no free segment is counted as lost, and the segments already stored are not changed.

Top module: `seg_fifo_ctrl`

## Requirements
- R1: After reset, free_cnt_o equals NSEG (128), while pend_cnt_o, lost_cnt_o, wr_active_o, dig_req_o and head_state_o are all 0.
- R2: A hit on an idle writer claims the segment at the head of the free list. After reset the free list holds the indices 0 to 127 in ascending order. From the next cycle, wr_active_o is 1 with that index on wr_seg_o, and wr_bin_o steps 0 to 31, one per clock, for 32 cycles.
- R3: In the cycle after bin 31, the segment is in the pending queue. pend_cnt_o rises by one, wr_active_o is 0 unless a new claim took place, head_state_o is 1 (awaiting decision) for the first pending entry, and dig_req_o stays 0.
- R4: A hit while a window is being written, other than during its last bin, is ignored. It makes no claim and does not count as lost.
- R5: A hit present during the last-bin cycle claims the next segment with no idle cycle between the two windows. The timestamps of the two segments differ by the number of clocks between their claims (32).
- R6: A level-2 accept (l2_accept_i=1) applied to the oldest pending segment raises dig_req_o, with that segment's index and timestamp on dig_seg_o and dig_ts_o, and sets head_state_o to 2. dig_ack_i removes the segment, returns its index to the free list and exposes the next pending segment in arrival order.
- R7: A level-2 reject (l2_accept_i=0) removes the oldest pending segment without ever raising dig_req_o. free_cnt_o is back up by one in the next cycle, and the rejected index is placed at the tail of the free list.
- R8: A level-2 decision is ignored while no pending segment awaits a decision, and dig_ack_i is ignored while dig_req_o is 0.
- R9: A hit that would claim a segment while free_cnt_o is 0 increments lost_cnt_o and leaves the pending queue unchanged. This holds even if a segment is released in the same cycle.
- R10: A claim and a release in the same cycle leave free_cnt_o unchanged. At every cycle, free_cnt_o + pend_cnt_o + wr_active_o equals NSEG.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hit_i | input | 1 | Trigger hit, sampled every clock |
| l2_valid_i | input | 1 | Level-2 decision strobe |
| l2_accept_i | input | 1 | Level-2 decision: 1 accept, 0 reject |
| dig_ack_i | input | 1 | Digitizer finished reading the requested segment |
| wr_active_o | output | 1 | A segment window is being written |
| wr_seg_o | output | 7 | Index of the segment being written |
| wr_bin_o | output | 5 | Bin being written inside the segment |
| dig_req_o | output | 1 | Readout request for the oldest pending segment |
| dig_seg_o | output | 7 | Index of the oldest pending segment |
| dig_ts_o | output | 16 | Hit timestamp of the oldest pending segment |
| free_cnt_o | output | 8 | Number of free segments |
| pend_cnt_o | output | 8 | Number of pending segments |
| lost_cnt_o | output | 16 | Saturating count of hits lost for lack of a free segment |
| head_state_o | output | 2 | 0 no pending segment, 1 awaiting decision, 2 awaiting digitizer |

## Verification
Claiming a segment and freeing one touch the same free list, and both can fall on the same clock edge. The bench fills all 128 segments and then provokes two such edges. In the first, a hit coincides with a reject while the list is empty: the hit must be lost and the freed index must survive. In the second, a hit coincides with a digitizer acknowledge while one segment is free: the hit must take exactly that segment and the free count must stay at one. Both cases are judged at the ports through the counts, the new write index and the lost counter, in the cycle after the shared edge.

// File: rtl/seg_fifo_pkg.sv
// Shared types for the segmented analog FIFO controller.
// Assumes nothing beyond IEEE 1800-2017 enums.
package seg_fifo_pkg;
    // Readout state of the oldest pending segment.
    typedef enum logic [1:0] {
        HS_EMPTY    = 2'd0,
        HS_WAIT_L2  = 2'd1,
        HS_WAIT_DIG = 2'd2
    } head_state_e;
endpackage

// File: rtl/seg_idx_queue.sv
// Circular queue of fixed-width entries with single push and single pop.
// When INIT_FULL is set, reset fills it with the entries 0..DEPTH-1 in
// ascending order. Assumes the user never pushes into a full queue or pops
// an empty one; such requests are dropped. The head is valid while count_o
// is nonzero.
module seg_idx_queue #(
    parameter int DEPTH     = 128,
    parameter int W         = 7,
    parameter bit INIT_FULL = 1'b0,
    parameter int CW        = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [W-1:0]  push_data_i,
    input  logic          pop_i,
    output logic [W-1:0]  head_o,
    output logic [CW-1:0] count_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rptr, wptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    // Advance a pointer with wrap at DEPTH.
    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    // Qualify requests against occupancy.
    always_comb begin
        do_push = push_i && (count != CW'(DEPTH));
        do_pop  = pop_i && (count != '0);
    end

    // Storage, pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= INIT_FULL ? W'(i) : '0;
            rptr  <= '0;
            wptr  <= '0;
            count <= INIT_FULL ? CW'(DEPTH) : '0;
        end else begin
            if (do_push) begin
                mem[wptr] <= push_data_i;
                wptr      <= ptr_next(wptr);
            end
            if (do_pop)
                rptr <= ptr_next(rptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    assign head_o  = mem[rptr];
    assign count_o = count;
endmodule

// File: rtl/seg_write_seq.sv
// Write sequencer: a hit claims the free-list head and the sequencer steps
// through SEG_BINS bins, then hands the segment and its hit timestamp to
// the pending queue. A hit in the last-bin cycle chains straight into the
// next window. Hits earlier in a window are ignored. A hit that finds the
// free list empty is counted as lost (saturating).
module seg_write_seq #(
    parameter int SEG_BINS = 32,
    parameter int TS_W     = 16,
    parameter int LOST_W   = 16,
    parameter int IDX_W    = 7,
    parameter int BIN_W    = 5,
    parameter int CNT_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_i,
    input  logic [CNT_W-1:0]  free_cnt_i,
    input  logic [IDX_W-1:0]  free_head_i,
    input  logic [TS_W-1:0]   ts_i,
    output logic              claim_o,
    output logic              done_o,
    output logic [IDX_W-1:0]  done_seg_o,
    output logic [TS_W-1:0]   done_ts_o,
    output logic              wr_active_o,
    output logic [IDX_W-1:0]  wr_seg_o,
    output logic [BIN_W-1:0]  wr_bin_o,
    output logic [LOST_W-1:0] lost_cnt_o
);
    logic              active;
    logic [IDX_W-1:0]  seg;
    logic [BIN_W-1:0]  bin;
    logic [TS_W-1:0]   ts_q;
    logic [LOST_W-1:0] lost;
    logic              last, ready, lose;

    // Decide claim and loss from the current window position.
    always_comb begin
        last    = active && (bin == BIN_W'(SEG_BINS - 1));
        ready   = !active || last;
        claim_o = hit_i && ready && (free_cnt_i != '0);
        lose    = hit_i && ready && (free_cnt_i == '0);
    end

    // Window position, segment index and timestamp.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            seg    <= '0;
            bin    <= '0;
            ts_q   <= '0;
        end else if (claim_o) begin
            active <= 1'b1;
            seg    <= free_head_i;
            bin    <= '0;
            ts_q   <= ts_i;
        end else if (last) begin
            active <= 1'b0;
        end else if (active) begin
            bin <= bin + BIN_W'(1);
        end
    end

    // Saturating count of lost hits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lost <= '0;
        else if (lose && (lost != '1))
            lost <= lost + LOST_W'(1);
    end

    assign done_o      = last;
    assign done_seg_o  = seg;
    assign done_ts_o   = ts_q;
    assign wr_active_o = active;
    assign wr_seg_o    = seg;
    assign wr_bin_o    = bin;
    assign lost_cnt_o  = lost;
endmodule

// File: rtl/seg_readout_ctrl.sv
// Readout control for the oldest pending segment: it waits for a level-2
// decision, drops the segment on a reject, and on an accept raises the
// digitizer request until the acknowledge arrives. Assumes dig_ack is a
// one-cycle pulse given only while the request is high; others are ignored.
module seg_readout_ctrl #(
    parameter int CNT_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CNT_W-1:0]          pend_cnt_i,
    input  logic                      l2_valid_i,
    input  logic                      l2_accept_i,
    input  logic                      dig_ack_i,
    output logic                      pop_o,
    output logic                      dig_req_o,
    output seg_fifo_pkg::head_state_e head_state_o
);
    import seg_fifo_pkg::*;

    logic acc_q;
    logic nonempty, decide, reject, take;

    // Qualify decision and acknowledge against the head state.
    always_comb begin
        nonempty = (pend_cnt_i != '0);
        decide   = l2_valid_i && nonempty && !acc_q;
        reject   = decide && !l2_accept_i;
        take     = dig_ack_i && acc_q;
        pop_o    = reject || take;
        if (!nonempty)  head_state_o = HS_EMPTY;
        else if (acc_q) head_state_o = HS_WAIT_DIG;
        else            head_state_o = HS_WAIT_L2;
    end

    // Accepted flag for the current head.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= 1'b0;
        else if (decide && l2_accept_i)
            acc_q <= 1'b1;
        else if (take)
            acc_q <= 1'b0;
    end

    assign dig_req_o = acc_q;
endmodule

// File: rtl/seg_fifo_ctrl.sv
// Segmented analog FIFO controller top. It holds a free list of segment
// indices, a pending queue of {index, timestamp} in arrival order, the write
// sequencer and the readout control. An index is released only by a
// digitizer acknowledge or a level-2 reject. The parameters after LOST_W
// are derived widths and must keep their defaults.
module seg_fifo_ctrl #(
    parameter int NSEG     = 128,
    parameter int SEG_BINS = 32,
    parameter int TS_W     = 16,
    parameter int LOST_W   = 16,
    parameter int IDX_W    = $clog2(NSEG),
    parameter int BIN_W    = $clog2(SEG_BINS),
    parameter int CNT_W    = $clog2(NSEG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_i,
    input  logic              l2_valid_i,
    input  logic              l2_accept_i,
    input  logic              dig_ack_i,
    output logic              wr_active_o,
    output logic [IDX_W-1:0]  wr_seg_o,
    output logic [BIN_W-1:0]  wr_bin_o,
    output logic              dig_req_o,
    output logic [IDX_W-1:0]  dig_seg_o,
    output logic [TS_W-1:0]   dig_ts_o,
    output logic [CNT_W-1:0]  free_cnt_o,
    output logic [CNT_W-1:0]  pend_cnt_o,
    output logic [LOST_W-1:0] lost_cnt_o,
    output logic [1:0]        head_state_o
);
    import seg_fifo_pkg::*;

    localparam int PEND_W = IDX_W + TS_W;

    logic [TS_W-1:0]   ts_cnt;
    logic              claim, done, pend_pop;
    logic [IDX_W-1:0]  free_head, done_seg;
    logic [TS_W-1:0]   done_ts;
    logic [PEND_W-1:0] pend_head;
    head_state_e       head_state;

    // Free-running timestamp counter.
    always_ff @(posedge clk) begin
        if (!rst_n) ts_cnt <= '0;
        else        ts_cnt <= ts_cnt + TS_W'(1);
    end

    seg_idx_queue #(.DEPTH(NSEG), .W(IDX_W), .INIT_FULL(1'b1), .CW(CNT_W)) u_free (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (pend_pop),
        .push_data_i (pend_head[PEND_W-1:TS_W]),
        .pop_i       (claim),
        .head_o      (free_head),
        .count_o     (free_cnt_o)
    );

    seg_idx_queue #(.DEPTH(NSEG), .W(PEND_W), .INIT_FULL(1'b0), .CW(CNT_W)) u_pend (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (done),
        .push_data_i ({done_seg, done_ts}),
        .pop_i       (pend_pop),
        .head_o      (pend_head),
        .count_o     (pend_cnt_o)
    );

    seg_write_seq #(.SEG_BINS(SEG_BINS), .TS_W(TS_W), .LOST_W(LOST_W),
                    .IDX_W(IDX_W), .BIN_W(BIN_W), .CNT_W(CNT_W)) u_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_i       (hit_i),
        .free_cnt_i  (free_cnt_o),
        .free_head_i (free_head),
        .ts_i        (ts_cnt),
        .claim_o     (claim),
        .done_o      (done),
        .done_seg_o  (done_seg),
        .done_ts_o   (done_ts),
        .wr_active_o (wr_active_o),
        .wr_seg_o    (wr_seg_o),
        .wr_bin_o    (wr_bin_o),
        .lost_cnt_o  (lost_cnt_o)
    );

    seg_readout_ctrl #(.CNT_W(CNT_W)) u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .pend_cnt_i   (pend_cnt_o),
        .l2_valid_i   (l2_valid_i),
        .l2_accept_i  (l2_accept_i),
        .dig_ack_i    (dig_ack_i),
        .pop_o        (pend_pop),
        .dig_req_o    (dig_req_o),
        .head_state_o (head_state)
    );

    assign dig_seg_o    = pend_head[PEND_W-1:TS_W];
    assign dig_ts_o     = pend_head[TS_W-1:0];
    assign head_state_o = head_state;
endmodule

// File: rtl/seg_fifo_ctrl_chk.sv
// Checker for seg_fifo_ctrl, observing its ports only; attached by bind.
module seg_fifo_ctrl_chk #(
    parameter int NSEG     = 128,
    parameter int SEG_BINS = 32,
    parameter int IDX_W    = 7,
    parameter int BIN_W    = 5,
    parameter int CNT_W    = 8,
    parameter int LOST_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hit_i,
    input logic              l2_valid_i,
    input logic              l2_accept_i,
    input logic              dig_ack_i,
    input logic              wr_active_o,
    input logic [IDX_W-1:0]  wr_seg_o,
    input logic [BIN_W-1:0]  wr_bin_o,
    input logic              dig_req_o,
    input logic [IDX_W-1:0]  dig_seg_o,
    input logic [CNT_W-1:0]  free_cnt_o,
    input logic [CNT_W-1:0]  pend_cnt_o,
    input logic [LOST_W-1:0] lost_cnt_o,
    input logic [1:0]        head_state_o
);
    logic in_last;
    assign in_last = wr_active_o && (wr_bin_o == BIN_W'(SEG_BINS - 1));

    // R10: every segment is free, pending or being written.
    assert_conserve_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(free_cnt_o) + int'(pend_cnt_o) + (wr_active_o ? 1 : 0)) == NSEG);

    // R2: bins advance by one per clock inside a window.
    assert_bin_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_active_o && !in_last) |=> (wr_active_o && wr_bin_o == $past(wr_bin_o) + BIN_W'(1)));

    // R4: mid-window hits change neither the segment nor the lost count.
    assert_mid_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_active_o && !in_last) |=> ($stable(wr_seg_o) && $stable(lost_cnt_o)));

    // R9: a claim attempt with no free segment is counted.
    assert_lost_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && (!wr_active_o || in_last) && free_cnt_o == '0 && lost_cnt_o != '1)
        |=> (lost_cnt_o == $past(lost_cnt_o) + LOST_W'(1)));

    // R6: a request holds its segment until acknowledged.
    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_req_o && !dig_ack_i) |=> (dig_req_o && $stable(dig_seg_o)));

    // R7: a reject frees the head segment by the next cycle.
    assert_reject_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (l2_valid_i && !l2_accept_i && head_state_o == 2'd1 && !hit_i)
        |=> (free_cnt_o == $past(free_cnt_o) + CNT_W'(1) && !dig_req_o));
endmodule

bind seg_fifo_ctrl seg_fifo_ctrl_chk #(
    .NSEG(NSEG), .SEG_BINS(SEG_BINS), .IDX_W(IDX_W),
    .BIN_W(BIN_W), .CNT_W(CNT_W), .LOST_W(LOST_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .l2_valid_i(l2_valid_i),
    .l2_accept_i(l2_accept_i), .dig_ack_i(dig_ack_i), .wr_active_o(wr_active_o),
    .wr_seg_o(wr_seg_o), .wr_bin_o(wr_bin_o), .dig_req_o(dig_req_o),
    .dig_seg_o(dig_seg_o), .free_cnt_o(free_cnt_o), .pend_cnt_o(pend_cnt_o),
    .lost_cnt_o(lost_cnt_o), .head_state_o(head_state_o)
);

// File: tb/seg_fifo_ctrl_tb.sv
// Directed bench for seg_fifo_ctrl: one task per scenario, each checks itself.
module seg_fifo_ctrl_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hit_i = 1'b0, l2_valid_i = 1'b0, l2_accept_i = 1'b0, dig_ack_i = 1'b0;
    logic        wr_active_o, dig_req_o;
    logic [6:0]  wr_seg_o, dig_seg_o;
    logic [4:0]  wr_bin_o;
    logic [15:0] dig_ts_o, lost_cnt_o;
    logic [7:0]  free_cnt_o, pend_cnt_o;
    logic [1:0]  head_state_o;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    seg_fifo_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .l2_valid_i(l2_valid_i),
        .l2_accept_i(l2_accept_i), .dig_ack_i(dig_ack_i), .wr_active_o(wr_active_o),
        .wr_seg_o(wr_seg_o), .wr_bin_o(wr_bin_o), .dig_req_o(dig_req_o),
        .dig_seg_o(dig_seg_o), .dig_ts_o(dig_ts_o), .free_cnt_o(free_cnt_o),
        .pend_cnt_o(pend_cnt_o), .lost_cnt_o(lost_cnt_o), .head_state_o(head_state_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; hit_i = 0; l2_valid_i = 0; l2_accept_i = 0; dig_ack_i = 0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
    endtask

    // One hit, then wait until its window is in the pending queue.
    task automatic capture_one();
        hit_i = 1; tick(); hit_i = 0;
        repeat (32) tick();
    endtask

    task automatic l2(input bit acc);
        l2_valid_i = 1; l2_accept_i = acc; tick(); l2_valid_i = 0; l2_accept_i = 0;
    endtask

    task automatic ack();
        dig_ack_i = 1; tick(); dig_ack_i = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "free", free_cnt_o, 128);
        chk("R1", "pend", pend_cnt_o, 0);
        chk("R1", "lost", lost_cnt_o, 0);
        chk("R1", "wr_active", wr_active_o, 0);
        chk("R1", "dig_req", dig_req_o, 0);
        chk("R1", "head_state", head_state_o, 0);
    endtask

    task automatic t_single();
        do_reset();
        hit_i = 1; tick(); hit_i = 0;
        chk("R2", "wr_active", wr_active_o, 1);
        chk("R2", "wr_seg", wr_seg_o, 0);
        chk("R2", "wr_bin first", wr_bin_o, 0);
        chk("R2", "free after claim", free_cnt_o, 127);
        repeat (31) tick();
        chk("R2", "wr_bin last", wr_bin_o, 31);
        chk("R2", "still active", wr_active_o, 1);
        tick();
        chk("R3", "wr_active", wr_active_o, 0);
        chk("R3", "pend", pend_cnt_o, 1);
        chk("R3", "head_state", head_state_o, 1);
        chk("R3", "dig_req", dig_req_o, 0);
        chk("R3", "dig_seg", dig_seg_o, 0);
    endtask

    task automatic t_mid_hit();
        do_reset();
        hit_i = 1; tick(); hit_i = 0;
        repeat (5) tick();
        hit_i = 1; tick(); hit_i = 0;
        chk("R4", "seg kept", wr_seg_o, 0);
        chk("R4", "bin continues", wr_bin_o, 6);
        chk("R4", "free", free_cnt_o, 127);
        chk("R4", "lost", lost_cnt_o, 0);
        repeat (26) tick();
        chk("R4", "pend", pend_cnt_o, 1);
        chk("R4", "idle after window", wr_active_o, 0);
    endtask

    task automatic t_chain_readout();
        int ts0, ts1;
        do_reset();
        hit_i = 1; tick();
        repeat (32) tick();
        hit_i = 0;
        chk("R5", "chained seg", wr_seg_o, 1);
        chk("R5", "chained bin", wr_bin_o, 0);
        chk("R5", "no gap", wr_active_o, 1);
        chk("R5", "pend", pend_cnt_o, 1);
        repeat (32) tick();
        chk("R5", "pend two", pend_cnt_o, 2);
        l2(1'b1);
        chk("R6", "dig_req", dig_req_o, 1);
        chk("R6", "dig_seg oldest", dig_seg_o, 0);
        chk("R6", "head_state", head_state_o, 2);
        ts0 = dig_ts_o;
        ack();
        chk("R6", "req dropped", dig_req_o, 0);
        chk("R6", "next head", dig_seg_o, 1);
        chk("R6", "head_state", head_state_o, 1);
        chk("R6", "free", free_cnt_o, 127);
        l2(1'b1);
        ts1 = dig_ts_o;
        chk("R5", "timestamp step", (ts1 - ts0) & 16'hFFFF, 32);
        ack();
        chk("R6", "free all", free_cnt_o, 128);
        chk("R6", "pend empty", pend_cnt_o, 0);
    endtask

    task automatic t_reject();
        do_reset();
        capture_one();
        l2(1'b0);
        chk("R7", "pend", pend_cnt_o, 0);
        chk("R7", "free", free_cnt_o, 128);
        chk("R7", "dig_req", dig_req_o, 0);
        hit_i = 1; tick(); hit_i = 0;
        chk("R7", "rejected idx to tail", wr_seg_o, 1);
    endtask

    task automatic t_ignored();
        do_reset();
        l2(1'b0);
        chk("R8", "l2 on empty head_state", head_state_o, 0);
        chk("R8", "l2 on empty free", free_cnt_o, 128);
        capture_one();
        ack();
        chk("R8", "ack without req pend", pend_cnt_o, 1);
        chk("R8", "ack without req state", head_state_o, 1);
        l2(1'b1);
        l2(1'b0);
        chk("R8", "second decision pend", pend_cnt_o, 1);
        chk("R8", "second decision req", dig_req_o, 1);
        chk("R8", "second decision free", free_cnt_o, 127);
    endtask

    task automatic t_fill_lost_collide();
        do_reset();
        hit_i = 1; tick();
        repeat (127 * 32) tick();
        hit_i = 0;
        chk("R5", "last chained seg", wr_seg_o, 127);
        repeat (32) tick();
        chk("R9", "pend full", pend_cnt_o, 128);
        chk("R9", "free empty", free_cnt_o, 0);
        chk("R9", "no loss yet", lost_cnt_o, 0);
        hit_i = 1; tick(); hit_i = 0;
        chk("R9", "lost", lost_cnt_o, 1);
        chk("R9", "pend unchanged", pend_cnt_o, 128);
        chk("R9", "head unchanged", dig_seg_o, 0);
        chk("R9", "no write", wr_active_o, 0);
        // Hit and reject on the same edge with an empty free list.
        hit_i = 1; l2_valid_i = 1; l2_accept_i = 0; tick();
        hit_i = 0; l2_valid_i = 0;
        chk("R9", "lost on collide", lost_cnt_o, 2);
        chk("R9", "freed survives", free_cnt_o, 1);
        chk("R9", "no write on collide", wr_active_o, 0);
        chk("R7", "next head", dig_seg_o, 1);
        l2(1'b1);
        // Claim of the last free segment and release on the same edge.
        hit_i = 1; dig_ack_i = 1; tick();
        hit_i = 0; dig_ack_i = 0;
        chk("R10", "free unchanged", free_cnt_o, 1);
        chk("R10", "claimed seg", wr_seg_o, 0);
        chk("R10", "writing", wr_active_o, 1);
        chk("R10", "pend", pend_cnt_o, 126);
        chk("R10", "lost", lost_cnt_o, 2);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_single();
        t_mid_hit();
        t_chain_readout();
        t_reject();
        t_ignored();
        t_fill_lost_collide();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule